// File: doc/BRIEF.md
# USB Host Command/Status Event Controller

This block keeps the run and configuration bits of a USB host controller's command register, together with its six status flags: transfer-complete interrupt, transfer-error interrupt, resume seen, host system error, process error and halted. Each cycle it takes event strobes from the rest of the controller and updates these bits. The strobes are descriptor write-back interrupt requests, protocol faults, bus aborts, resume detection, a suspend request and a controller reset. It also drives a level interrupt, and it tracks whether the controller is in suspend.

Software has three ports. It writes the command bits through a load port. It clears status flags by writing ones to them. It programs a per-flag interrupt enable register. A fatal fault does two things in the same clock edge: it stops the controller and it records the cause. The halted flag always follows the run bit. Schedule walking, root ports and the system bus interface are outside this block.

Status bit positions: [0] transfer interrupt, [1] error interrupt, [2] resume seen, [3] host system error, [4] process error, [5] halted. The interrupt enable register uses the same positions.

Top module: `usbh_cmdsts_ctrl`

## Requirements
- R1: A protocol fault strobe (`ev_proto_i`) clears `run_o` and sets status bits 4 and 5 at the next clock edge.
- R2: A bus abort strobe (`ev_abort_i`) clears `run_o` and sets status bits 3 and 5 at the next clock edge.
- R3: Whenever `run_o` goes from 1 to 0, status bit 5 (halted) becomes 1. Setting `run_o` to 1 clears bit 5. `run_o` and bit 5 are never 1 at the same time.
- R4: A suspend request while `run_o` is 0 sets `suspended_o` at the next edge. A suspend request while `run_o` is 1 is ignored.
- R5: A resume strobe while `suspended_o` is 1 sets status bit 2 and clears `suspended_o`. A resume strobe while not suspended changes nothing.
- R6: A command write (`cmd_we_i`) loads `run_o` from `cmd_run_i` and `cfg_o` from `cmd_cfg_i` at the next edge.
- R7: A controller reset strobe clears `run_o`, `cfg_o`, `suspended_o` and all six status bits at the next edge. It overrides every other event in the same cycle. It does not touch the enable register.
- R8: A transfer-interrupt strobe sets status bit 0. An error-interrupt strobe sets status bit 1.
- R9: Writing a one to bits 0 to 4 of `sts_clr_i` clears those status bits. A hardware set in the same cycle wins over the clear. A one in bit 5 has no effect.
- R10: `irq_o` equals the OR over all six bits of `sts_o & ien_o`, in the same cycle as those values. `ien_we_i` loads `ien_o` from `ien_i`.
- R11: A fault or abort in the same cycle as a command write with `cmd_run_i`=1 leaves `run_o` at 0.
- R12: After the synchronous reset `rst`, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_run_i | input | 1 | Run value to load |
| cmd_cfg_i | input | 1 | Configuration flag value to load |
| sts_clr_i | input | 6 | Write-one-to-clear mask for status bits |
| ien_we_i | input | 1 | Interrupt enable write strobe |
| ien_i | input | 6 | Interrupt enable value |
| ev_ioc_i | input | 1 | Descriptor transfer-interrupt request |
| ev_err_i | input | 1 | Descriptor error-interrupt request |
| ev_proto_i | input | 1 | Protocol fault (bad PID, PID error, illegal length) |
| ev_abort_i | input | 1 | Bus master or target abort |
| ev_resume_i | input | 1 | Resume detected on the bus |
| ev_susp_req_i | input | 1 | Request to enter suspend |
| ev_hc_reset_i | input | 1 | Controller or global reset strobe |
| run_o | output | 1 | Run bit |
| cfg_o | output | 1 | Configuration flag |
| suspended_o | output | 1 | Controller is in suspend |
| sts_o | output | 6 | Status bits |
| ien_o | output | 6 | Interrupt enable register |
| irq_o | output | 1 | Interrupt level |

## Verification
The assertions only assume that every input is a clean level sampled at the clock edge. Any mix of strobes may arrive in one cycle, and nothing has to be held between cycles. For the properties that check a single event, the assertions leave out cycles that also carry a controller reset, because the reset takes priority. The stimulus draws every strobe independently and at random each cycle, and it keeps the controller reset rare so that run, suspend and fault sequences have time to build up. Directed steps then add the collisions the rules single out: a fault during a start, a set during a clear, and a reset during other events.

// File: rtl/usbh_cs_pkg.sv
package usbh_cs_pkg;
  localparam int STS_W = 6;
  localparam int B_INT = 0;
  localparam int B_ERR = 1;
  localparam int B_RES = 2;
  localparam int B_HSE = 3;
  localparam int B_HPE = 4;
  localparam int B_HLT = 5;
  // bits software may clear; the halted bit follows the run bit instead
  localparam logic [STS_W-1:0] W1C_MASK = 6'b01_1111;

  typedef struct packed {
    logic ioc;
    logic err;
    logic proto;
    logic abort;
    logic resume;
    logic susp_req;
    logic hc_reset;
  } ev_t;
endpackage

// File: rtl/usbh_cmd_reg.sv
module usbh_cmd_reg
  import usbh_cs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  ev_t  ev,
  input  logic cmd_we,
  input  logic cmd_run,
  input  logic cmd_cfg,
  input  logic halt_q,
  output logic run_q,
  output logic cfg_q,
  output logic susp_q,
  output logic halt_d
);
  logic fatal;
  logic run_d;
  logic cfg_d;
  logic susp_d;

  assign fatal = ev.proto | ev.abort;

  always_comb begin
    // run: reset, then fatal events, then software
    if (ev.hc_reset)   run_d = 1'b0;
    else if (fatal)    run_d = 1'b0;
    else if (cmd_we)   run_d = cmd_run;
    else               run_d = run_q;

    if (ev.hc_reset)   cfg_d = 1'b0;
    else if (cmd_we)   cfg_d = cmd_cfg;
    else               cfg_d = cfg_q;

    // halted follows run: set on any stop, cleared on start
    if (ev.hc_reset)                     halt_d = 1'b0;
    else if (run_d)                      halt_d = 1'b0;
    else if (fatal || (run_q && !run_d)) halt_d = 1'b1;
    else                                 halt_d = halt_q;

    if (ev.hc_reset)                     susp_d = 1'b0;
    else if (ev.resume && susp_q)        susp_d = 1'b0;
    else if (ev.susp_req && !run_q)      susp_d = 1'b1;
    else                                 susp_d = susp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      cfg_q  <= 1'b0;
      susp_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      cfg_q  <= cfg_d;
      susp_q <= susp_d;
    end
  end
endmodule

// File: rtl/usbh_sts_reg.sv
module usbh_sts_reg #(
  parameter int W = 6,
  parameter logic [W-1:0] CLR_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hc_reset,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q,
  output logic [W-1:0] d
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (CLR_MASK[i]) begin : g_w1c
      // sticky flag: hardware set wins over software clear
      always_comb begin
        if (hc_reset) d[i] = 1'b0;
        else          d[i] = set[i] | (q[i] & ~clr[i]);
      end
    end else begin : g_track
      // level-tracked flag, loaded from its set input
      always_comb d[i] = set[i];
    end

    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= d[i];
    end
  end
endmodule

// File: rtl/usbh_irq_gen.sv
module usbh_irq_gen #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ien_we,
  input  logic [W-1:0] ien_in,
  input  logic [W-1:0] sts_d,
  output logic [W-1:0] ien_q,
  output logic         irq_q
);
  logic [W-1:0] ien_d;

  assign ien_d = ien_we ? ien_in : ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= '0;
      irq_q <= 1'b0;
    end else begin
      ien_q <= ien_d;
      irq_q <= |(sts_d & ien_d);
    end
  end
endmodule

// File: rtl/usbh_cmdsts_ctrl.sv
module usbh_cmdsts_ctrl
  import usbh_cs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we_i,
  input  logic             cmd_run_i,
  input  logic             cmd_cfg_i,
  input  logic [STS_W-1:0] sts_clr_i,
  input  logic             ien_we_i,
  input  logic [STS_W-1:0] ien_i,
  input  logic             ev_ioc_i,
  input  logic             ev_err_i,
  input  logic             ev_proto_i,
  input  logic             ev_abort_i,
  input  logic             ev_resume_i,
  input  logic             ev_susp_req_i,
  input  logic             ev_hc_reset_i,
  output logic             run_o,
  output logic             cfg_o,
  output logic             suspended_o,
  output logic [STS_W-1:0] sts_o,
  output logic [STS_W-1:0] ien_o,
  output logic             irq_o
);
  ev_t              ev;
  logic             halt_d;
  logic [STS_W-1:0] sts_set;
  logic [STS_W-1:0] sts_clr;
  logic [STS_W-1:0] sts_d;

  assign ev = '{ioc: ev_ioc_i, err: ev_err_i, proto: ev_proto_i,
                abort: ev_abort_i, resume: ev_resume_i,
                susp_req: ev_susp_req_i, hc_reset: ev_hc_reset_i};

  usbh_cmd_reg u_cmd (
    .clk     (clk),
    .rst     (rst),
    .ev      (ev),
    .cmd_we  (cmd_we_i),
    .cmd_run (cmd_run_i),
    .cmd_cfg (cmd_cfg_i),
    .halt_q  (sts_o[B_HLT]),
    .run_q   (run_o),
    .cfg_q   (cfg_o),
    .susp_q  (suspended_o),
    .halt_d  (halt_d)
  );

  always_comb begin
    sts_set        = '0;
    sts_set[B_INT] = ev_ioc_i;
    sts_set[B_ERR] = ev_err_i;
    sts_set[B_RES] = ev_resume_i & suspended_o;
    sts_set[B_HSE] = ev_abort_i;
    sts_set[B_HPE] = ev_proto_i;
    sts_set[B_HLT] = halt_d;
  end

  assign sts_clr = sts_clr_i & W1C_MASK;

  usbh_sts_reg #(.W(STS_W), .CLR_MASK(W1C_MASK)) u_sts (
    .clk      (clk),
    .rst      (rst),
    .hc_reset (ev_hc_reset_i),
    .set      (sts_set),
    .clr      (sts_clr),
    .q        (sts_o),
    .d        (sts_d)
  );

  usbh_irq_gen #(.W(STS_W)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .ien_we (ien_we_i),
    .ien_in (ien_i),
    .sts_d  (sts_d),
    .ien_q  (ien_o),
    .irq_q  (irq_o)
  );
endmodule

// File: rtl/usbh_cmdsts_chk.sv
module usbh_cmdsts_chk (
  input logic       clk,
  input logic       rst,
  input logic       ev_ioc_i,
  input logic       ev_proto_i,
  input logic       ev_abort_i,
  input logic       ev_susp_req_i,
  input logic       ev_hc_reset_i,
  input logic       run_o,
  input logic       cfg_o,
  input logic       suspended_o,
  input logic [5:0] sts_o,
  input logic [5:0] ien_o,
  input logic       irq_o
);
  p_fault_stops_r1: assert property (@(posedge clk) disable iff (rst)
    (ev_proto_i && !ev_hc_reset_i) |=> (!run_o && sts_o[4] && sts_o[5]));

  p_abort_stops_r2: assert property (@(posedge clk) disable iff (rst)
    (ev_abort_i && !ev_hc_reset_i) |=> (!run_o && sts_o[3] && sts_o[5]));

  p_run_not_halted_r3: assert property (@(posedge clk) disable iff (rst)
    run_o |-> !sts_o[5]);

  p_no_susp_running_r4: assert property (@(posedge clk) disable iff (rst)
    (ev_susp_req_i && run_o && !suspended_o) |=> !suspended_o);

  p_reset_clears_r7: assert property (@(posedge clk) disable iff (rst)
    ev_hc_reset_i |=> (!run_o && !cfg_o && !suspended_o && sts_o == 6'd0));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (ev_ioc_i && !ev_hc_reset_i) |=> sts_o[0]);

  p_irq_level_r10: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|(sts_o & ien_o)));
endmodule

bind usbh_cmdsts_ctrl usbh_cmdsts_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .ev_ioc_i      (ev_ioc_i),
  .ev_proto_i    (ev_proto_i),
  .ev_abort_i    (ev_abort_i),
  .ev_susp_req_i (ev_susp_req_i),
  .ev_hc_reset_i (ev_hc_reset_i),
  .run_o         (run_o),
  .cfg_o         (cfg_o),
  .suspended_o   (suspended_o),
  .sts_o         (sts_o),
  .ien_o         (ien_o),
  .irq_o         (irq_o)
);

// File: tb/usbh_cmdsts_ctrl_test.sv
module usbh_cmdsts_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_we = 0, cmd_run = 0, cmd_cfg = 0, ien_we = 0;
  logic [5:0] sts_clr = '0, ien_in = '0;
  logic ioc = 0, err = 0, proto = 0, abort = 0, resume = 0, sreq = 0, hcr = 0;
  logic run_o, cfg_o, susp_o, irq_o;
  logic [5:0] sts_o, ien_o;

  // expected state
  logic m_run = 0, m_cfg = 0, m_susp = 0, m_irq = 0;
  logic [5:0] m_sts = '0, m_ien = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  usbh_cmdsts_ctrl uut (
    .clk(clk), .rst(rst), .cmd_we_i(cmd_we), .cmd_run_i(cmd_run),
    .cmd_cfg_i(cmd_cfg), .sts_clr_i(sts_clr), .ien_we_i(ien_we),
    .ien_i(ien_in), .ev_ioc_i(ioc), .ev_err_i(err), .ev_proto_i(proto),
    .ev_abort_i(abort), .ev_resume_i(resume), .ev_susp_req_i(sreq),
    .ev_hc_reset_i(hcr), .run_o(run_o), .cfg_o(cfg_o),
    .suspended_o(susp_o), .sts_o(sts_o), .ien_o(ien_o), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !done) begin
      bad = bad + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<=50000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] next_sts(logic h, logic [5:0] s);
    logic [5:0] n;
    logic [5:0] set;
    set = {1'b0, proto, abort, resume & m_susp, err, ioc};
    n = (s & ~(sts_clr & 6'h1F)) | set;
    n[5] = h;
    return n;
  endfunction

  // model update from the rules, at a clock edge, before state changes
  task automatic model_edge();
    logic nrun, ncfg, nh, ns, fatal;
    logic [5:0] nsts, nien;
    fatal = proto | abort;
    if (rst) begin
      m_run = 0; m_cfg = 0; m_susp = 0; m_sts = '0; m_ien = '0; m_irq = 0;
      return;
    end
    nrun = hcr ? 1'b0 : fatal ? 1'b0 : cmd_we ? cmd_run : m_run;
    ncfg = hcr ? 1'b0 : cmd_we ? cmd_cfg : m_cfg;
    if (hcr) nh = 0;
    else if (nrun) nh = 0;
    else if (fatal || (m_run && !nrun)) nh = 1;
    else nh = m_sts[5];
    if (hcr) ns = 0;
    else if (resume && m_susp) ns = 0;
    else if (sreq && !m_run) ns = 1;
    else ns = m_susp;
    nsts = hcr ? 6'd0 : next_sts(nh, m_sts);
    nien = ien_we ? ien_in : m_ien;
    m_irq = |(nsts & nien);
    m_run = nrun; m_cfg = ncfg; m_susp = ns; m_sts = nsts; m_ien = nien;
  endtask

  task automatic compare_all();
    chk("R6 run", run_o, m_run);
    chk("R6 cfg", cfg_o, m_cfg);
    chk("R4 suspended", susp_o, m_susp);
    chk("R9 status", sts_o, m_sts);
    chk("R10 enable", ien_o, m_ien);
    chk("R10 irq", irq_o, m_irq);
  endtask

  task automatic idle_inputs();
    cmd_we = 0; cmd_run = 0; cmd_cfg = 0; ien_we = 0; sts_clr = '0; ien_in = '0;
    ioc = 0; err = 0; proto = 0; abort = 0; resume = 0; sreq = 0; hcr = 0;
  endtask

  // inputs are set at a falling edge; this applies one clock edge
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h0005_A1C3;
    void'($urandom(seed));
    idle_inputs();
    rst = 1;
    step(); step();
    rst = 0;
    // r12_ reset state
    chk("R12 reset run", run_o, 0);
    chk("R12 reset status", sts_o, 0);
    chk("R12 reset irq", irq_o, 0);

    cmd_we = 1; cmd_run = 1; cmd_cfg = 1; step();
    chk("R6 start", {run_o, cfg_o}, 2'b11);
    chk("R3 running not halted", sts_o[5], 0);

    sreq = 1; step();
    chk("R4 suspend ignored while running", susp_o, 0);

    ioc = 1; step();
    chk("R8 transfer int", sts_o[0], 1);
    err = 1; step();
    chk("R8 error int", sts_o[1], 1);

    ien_we = 1; ien_in = 6'h01; step();
    chk("R10 irq enabled", irq_o, 1);

    sts_clr = 6'h3F; ioc = 1; step();
    chk("R9 set wins over clear", sts_o[1:0], 2'b01);

    proto = 1; step();
    chk("R1 fault stops", {run_o, sts_o[5], sts_o[4]}, 3'b011);

    sts_clr = 6'h20; step();
    chk("R9 halted ignores clear", sts_o[5], 1);

    sreq = 1; step();
    chk("R4 suspend while stopped", susp_o, 1);

    resume = 1; step();
    chk("R5 resume seen", {sts_o[2], susp_o}, 2'b10);
    sts_clr = 6'h04; step();
    resume = 1; step();
    chk("R5 resume ignored when awake", sts_o[2], 0);

    cmd_we = 1; cmd_run = 1; cmd_cfg = 1; abort = 1; step();
    chk("R11 abort beats start", run_o, 0);
    chk("R2 abort status", {sts_o[5], sts_o[3]}, 2'b11);

    cmd_we = 1; cmd_run = 1; cmd_cfg = 1; step();
    chk("R3 start clears halted", {run_o, sts_o[5]}, 2'b10);
    cmd_we = 1; cmd_run = 0; cmd_cfg = 1; step();
    chk("R3 stop sets halted", sts_o[5], 1);

    ien_we = 1; ien_in = 6'h3F; step();
    hcr = 1; ioc = 1; proto = 1; sreq = 1; step();
    chk("R7 reset clears all", {run_o, cfg_o, susp_o, sts_o}, 9'd0);
    chk("R7 enable kept", ien_o, 6'h3F);

    for (int i = 0; i < 4000; i++) begin
      cmd_we  = ($urandom % 6) == 0;
      cmd_run = ($urandom % 4) != 0;
      cmd_cfg = $urandom % 2;
      sts_clr = (($urandom % 4) == 0) ? 6'($urandom) : 6'd0;
      ien_we  = ($urandom % 20) == 0;
      ien_in  = 6'($urandom);
      ioc     = ($urandom % 8) == 0;
      err     = ($urandom % 12) == 0;
      proto   = ($urandom % 30) == 0;
      abort   = ($urandom % 40) == 0;
      resume  = ($urandom % 10) == 0;
      sreq    = ($urandom % 8) == 0;
      hcr     = ($urandom % 60) == 0;
      step();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule